// File: doc/BRIEF.md
# Boot Page Select Slave

This block is a passive slave on an asynchronous system bus. It watches the eight upper address lines and the data strobe. When a master strobes an address in the boot page, the block enables one bank of an on-board boot ROM and drives a pair of response signals back to the master. The address lines and the strobe are active low. The block synchronizes them to its own clock and arms a select flag on the falling edge of the strobe. It keeps that flag until the strobe is released.

The boot page is the one whose positive-logic upper address byte is 0xFB. On the active-low lines, address line 10 is high and the other seven are low. Two static strap inputs choose which of four ROM banks the select drives. On a board with both straps tied high, only the fourth bank is ever enabled. The first three then stay inactive for good. The ROM contents, the data drivers and the bus arbitration are outside this block.

Top module: `boot_page_select`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the next outputs are idle: `resp_act`=0, `resp_act_n`=1 and `rom_bank_en_n`=4'hF.
- R2: The page decode is true only when `addr_n` (bit 0 is line 8, bit 7 is line 15) equals 8'b0000_0100. In positive logic, the upper byte is then 0xFB.
- R3: A falling edge of `strobe_n` while the page decode is true sets the select. The outputs change after the third rising clock edge that follows the input change, and not earlier.
- R4: `resp_act` is 1 and `resp_act_n` is 0 exactly while the block is selected. Otherwise they are 0 and 1. The two are always complements of each other.
- R5: While the block is selected, the bit of `rom_bank_en_n` whose index equals `strap_sel` is 0 and the other three bits are 1. With `strap_sel`=2'b11, only bit 3 is ever 0.
- R6: When `strobe_n` returns high, the select clears after the third rising clock edge that follows.
- R7: A strobe falling edge with any address outside the boot page leaves every output idle.
- R8: The address is only examined at the strobe falling edge. Moving the address into the page while the strobe stays low does not select the block. Moving it out of the page while the strobe stays low does not deselect it.
- R9: A strobe held low across a reset does not count as a new falling edge. The block stays idle until the strobe is released and then falls again in the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_n | input | 8 | Upper address lines 8..15, active low, asynchronous |
| strobe_n | input | 1 | Bus data strobe, active low, asynchronous |
| strap_sel | input | 2 | Static strap choosing the ROM bank (tied 2'b11 on a standard board) |
| resp_act | output | 1 | Response active, active high |
| resp_act_n | output | 1 | Response active, active low |
| rom_bank_en_n | output | 4 | ROM bank enables, active low |

## Verification
Every change on `strobe_n` passes through two synchronizer flops and then sets or clears the select flag. Each output change is therefore due right after the third rising edge that follows the input change. The bench drives inputs on the falling edge, waits three rising edges and samples on the next falling edge. In one directed test it also samples after only two rising edges, to confirm the output has not yet moved. Reset acts on the first rising edge, so its results are sampled one falling edge after that edge.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam int ADDR_W      = 8;
  localparam int BANKS       = 4;
  localparam int STRAP_W     = $clog2(BANKS);
  localparam int SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] BOOT_PAGE = 8'hFB;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [STRAP_W-1:0] strap_t;
  typedef logic [BANKS-1:0]   bank_t;

  function automatic logic page_match(addr_t lines_n, addr_t page);
    return (~lines_n) == page;
  endfunction
endpackage

// File: rtl/bsel_sync.sv
module bsel_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bsel_front.sv
module bsel_front
  import boot_sel_pkg::*;
#(
  parameter addr_t PAGE = BOOT_PAGE
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  strb_s_n,
  input  addr_t addr_s_n,
  output logic  fall,
  output logic  release_q,
  output logic  hit
);
  logic strb_prev_n;

  // reset value 0: a strobe held low across reset is not a fresh edge
  always_ff @(posedge clk) begin
    if (rst) strb_prev_n <= 1'b0;
    else     strb_prev_n <= strb_s_n;
  end

  assign fall      = strb_prev_n & ~strb_s_n;
  assign release_q = strb_s_n;
  assign hit       = page_match(addr_s_n, PAGE);
endmodule

// File: rtl/bsel_flag.sv
module bsel_flag
  import boot_sel_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   fall,
  input  logic   release_q,
  input  logic   hit,
  input  strap_t strap_sel,
  output logic   resp_act,
  output logic   resp_act_n,
  output bank_t  rom_bank_en_n
);
  logic sel_q;
  logic sel_d;

  always_comb begin
    sel_d = sel_q;
    if (release_q)        sel_d = 1'b0;
    else if (fall && hit) sel_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel_d;
  end

  assign resp_act   = sel_q;
  assign resp_act_n = ~sel_q;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      assign rom_bank_en_n[b] = ~(sel_q && (strap_sel == strap_t'(b)));
    end
  endgenerate
endmodule

// File: rtl/boot_page_select.sv
module boot_page_select
  import boot_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr_n,
  input  logic        strobe_n,
  input  logic [1:0]  strap_sel,
  output logic        resp_act,
  output logic        resp_act_n,
  output logic [3:0]  rom_bank_en_n
);
  logic  strb_s_n;
  addr_t addr_s_n;
  logic  fall, release_q, hit;

  bsel_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strb (
    .clk(clk), .rst(rst), .d(strobe_n), .q(strb_s_n)
  );

  bsel_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL({ADDR_W{1'b1}})) u_sync_addr (
    .clk(clk), .rst(rst), .d(addr_n), .q(addr_s_n)
  );

  bsel_front #(.PAGE(BOOT_PAGE)) u_front (
    .clk(clk), .rst(rst), .strb_s_n(strb_s_n), .addr_s_n(addr_s_n),
    .fall(fall), .release_q(release_q), .hit(hit)
  );

  bsel_flag u_flag (
    .clk(clk), .rst(rst), .fall(fall), .release_q(release_q), .hit(hit),
    .strap_sel(strap_sel), .resp_act(resp_act), .resp_act_n(resp_act_n),
    .rom_bank_en_n(rom_bank_en_n)
  );
endmodule

// File: rtl/boot_page_select_chk.sv
module boot_page_select_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr_n,
  input logic       strobe_n,
  input logic [1:0] strap_sel,
  input logic       resp_act,
  input logic       resp_act_n,
  input logic [3:0] rom_bank_en_n
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!resp_act && resp_act_n && rom_bank_en_n == 4'hF)); // R1

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) resp_act != resp_act_n); // R4

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(~rom_bank_en_n)); // R5

  AST_BANK_FOLLOWS_STRAP: assert property (@(posedge clk) disable iff (rst)
    resp_act |-> (rom_bank_en_n[strap_sel] == 1'b0)); // R5

  AST_IDLE_NO_BANK: assert property (@(posedge clk) disable iff (rst)
    !resp_act |-> (rom_bank_en_n == 4'hF)); // R4

  AST_SET_NEEDS_PAGE: assert property (@(posedge clk) disable iff (rst)
    $rose(resp_act) |-> ($past(strobe_n, 3) == 1'b0 && $past(addr_n, 3) == 8'h04)); // R7

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    (resp_act && !$past(strobe_n, 2)) |=> resp_act); // R8

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(strobe_n, 2) |=> !resp_act); // R6
endmodule

bind boot_page_select boot_page_select_chk u_chk (
  .clk(clk), .rst(rst), .addr_n(addr_n), .strobe_n(strobe_n), .strap_sel(strap_sel),
  .resp_act(resp_act), .resp_act_n(resp_act_n), .rom_bank_en_n(rom_bank_en_n)
);

// File: tb/boot_page_select_tb_top.sv
module boot_page_select_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;
  // {expect_select, strap[1:0], addr_n[7:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 2'd3, 8'h04}, {1'b1, 2'd0, 8'h04}, {1'b1, 2'd1, 8'h04},
    {1'b1, 2'd2, 8'h04}, {1'b0, 2'd3, 8'h00}, {1'b0, 2'd3, 8'hFB},
    {1'b0, 2'd3, 8'h05}, {1'b0, 2'd3, 8'h06}, {1'b0, 2'd3, 8'h84},
    {1'b0, 2'd3, 8'hFF}, {1'b1, 2'd3, 8'h04}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr_n = 8'hFF;
  logic       strobe_n = 1'b1;
  logic [1:0] strap_sel = 2'b11;
  logic       resp_act, resp_act_n;
  logic [3:0] rom_bank_en_n;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boot_page_select dut_i (
    .clk(clk), .rst(rst), .addr_n(addr_n), .strobe_n(strobe_n), .strap_sel(strap_sel),
    .resp_act(resp_act), .resp_act_n(resp_act_n), .rom_bank_en_n(rom_bank_en_n)
  );

  function automatic logic [5:0] expect_out(logic sel, logic [1:0] strap);
    logic [3:0] en = 4'hF;
    if (sel) en[strap] = 1'b0;
    return {sel, ~sel, en};
  endfunction

  task automatic check(string req, logic sel);
    logic [5:0] act = {resp_act, resp_act_n, rom_bank_en_n};
    logic [5:0] exp = expect_out(sel, strap_sel);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_due();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset idle", 1'b0);
    rst = 1'b0;
    wait_due();
    check("R1 idle after reset", 1'b0);

    // vector table: strobe fall, check, release, check
    for (int i = 0; i < NVEC; i++) begin
      strap_sel = VEC[i][9:8];
      addr_n    = VEC[i][7:0];
      wait_due();
      strobe_n = 1'b0;
      wait_due();
      check(VEC[i][10] ? "R2 R5 page select" : "R7 off page idle", VEC[i][10]);
      strobe_n = 1'b1;
      wait_due();
      check("R6 release clears", 1'b0);
    end

    // R3 latency: not after two edges, yes after three
    strap_sel = 2'b11; addr_n = 8'h04;
    wait_due();
    strobe_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 not before third edge", 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R3 due after third edge", 1'b1);
    strobe_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 held until third edge", 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R6 cleared at third edge", 1'b0);

    // R8: address moves in while strobe stays low
    addr_n = 8'h00;
    wait_due();
    strobe_n = 1'b0;
    wait_due();
    addr_n = 8'h04;
    wait_due(); wait_due();
    check("R8 late page entry ignored", 1'b0);
    strobe_n = 1'b1;
    wait_due();
    strobe_n = 1'b0;
    wait_due();
    check("R8 selected on fresh edge", 1'b1);
    addr_n = 8'h00;
    wait_due(); wait_due();
    check("R8 page exit ignored while low", 1'b1);
    strobe_n = 1'b1; addr_n = 8'h04;
    wait_due();
    check("R6 cleared", 1'b0);

    // R9: reset with strobe held low
    strobe_n = 1'b0;
    wait_due();
    check("R9 selected before reset", 1'b1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 R9 reset clears select", 1'b0);
    rst = 1'b0;
    wait_due(); wait_due();
    check("R9 held strobe not a new edge", 1'b0);
    strobe_n = 1'b1;
    wait_due();
    strobe_n = 1'b0;
    wait_due();
    check("R9 select after fresh edge", 1'b1);
    strobe_n = 1'b1;
    wait_due();

    // R7 sweep of every address except the boot page
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h04) begin
        addr_n = 8'(a);
        wait_due();
        strobe_n = 1'b0;
        wait_due();
        check("R7 sweep off page", 1'b0);
        strobe_n = 1'b1;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule